// File: doc/BRIEF.md
# Conditional Branch Decision and Target Unit

This unit takes one branch-class instruction at a time, together with the program counter of the word that follows it, the four condition flags and the current value of a loop counter register. It decides whether the branch is taken, produces the next program counter and, for the counting loop form, returns the decremented counter value with a write strobe. The fetch logic, the execution of other instruction classes and the flag generation all stay outside the unit.

The instruction word has two bytes. The upper byte selects the kind of branch, and the lower byte is a signed displacement counted in words. The unit sign-extends the displacement, doubles it and adds it to the program counter, with the sum wrapping at 16 bits. Signed and unsigned comparisons both read the same four flags: negative, zero, overflow and carry. The loop form decrements the counter and branches only when the new value is not zero.

Work arrives on a valid/ready input stream. Each accepted instruction produces exactly one result on a valid/ready output stream, one cycle later. A single output register sits between the two streams. The input is ready whenever that register is empty or is being drained in the same cycle. While the output is stalled, the result stays unchanged until the consumer takes it.

Top module: `bcu_branch_unit`

## Requirements
- R1: While reset is asserted, and right after it, `out_valid` is 0 and `in_ready` is 1.
- R2: `in_ready` is 1 exactly when the output register is empty or `out_ready` is 1. While `out_valid` is 1 and `out_ready` is 0, every output field holds its value in the next cycle.
- R3: For a taken branch, `out_pc` equals `in_pc` plus twice the sign-extended low byte of `in_instr`, modulo 2^16.
- R4: When a branch is not taken, `out_pc` equals `in_pc` unchanged.
- R5: The simple flag tests use these upper-byte codes. 0x10 is always taken. 0x11 is taken when Z=0, and 0x12 when Z=1. 0x13 is taken when N=0, and 0x14 when N=1. 0x15 is taken when V=0, and 0x16 when V=1. 0x17 is taken when C=0, and 0x18 when C=1. The flags arrive on `in_flags` as {N,Z,V,C}, with N in bit 3 and C in bit 0.
- R6: The signed tests are: 0x19 (≥0) is taken when N^V=0. 0x1A (<0) is taken when N^V=1. 0x1B (>0) is taken when Z|(N^V)=0. 0x1C (≤0) is taken when Z|(N^V)=1.
- R7: The unsigned tests are: lower is taken when C=1, and higher-or-same when C=0. These two share codes 0x18 and 0x17. 0x1D (higher) is taken when C|Z=0. 0x1E (lower-or-same) is taken when C|Z=1.
- R8: Code 0x1F is the loop form. It sets `out_count_wr` to 1 and `out_count` to `in_count`-1 (wrapping, so 0 gives 0xFFFF). The branch is taken exactly when that result is not zero.
- R9: Any other upper-byte value is not a branch. For such a word, `out_taken` is 0, `out_count_wr` is 0 and `out_pc` equals `in_pc`.
- R10: Every accepted input gives exactly one output. Results leave in acceptance order, and `out_valid` is 1 in the cycle after the acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input instruction is present |
| in_ready | output | 1 | Unit can accept the input this cycle |
| in_instr | input | 16 | Branch instruction word (upper byte kind, lower byte word offset) |
| in_pc | input | 16 | Program counter of the word after the branch |
| in_flags | input | 4 | Condition flags {N,Z,V,C} |
| in_count | input | 16 | Current loop counter register value |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_taken | output | 1 | Branch is taken |
| out_pc | output | 16 | Next program counter |
| out_count | output | 16 | Decremented counter value (meaningful with the write strobe) |
| out_count_wr | output | 1 | Write `out_count` back to the counter register |

## Verification
The hardest case to reach from the ports is a result held in a stalled output register while a new instruction waits at the input. The output must stay frozen, and the waiting word must not overwrite it. The stimulus reaches this case by dropping `out_ready` at random in about one cycle in four while inputs keep arriving. It then compares each held value across the stall. The loop-form edges also need explicit stimulus: a counter of 1 (the branch falls through) and a counter of 0 (wraps to 0xFFFF and is taken). So do displacements of 0x80 and 0x7F and program counter wrap in both directions. These are driven as directed words ahead of a sweep of every code against all sixteen flag combinations.

// File: rtl/bcu_pkg.sv
`timescale 1ns/1ps
package bcu_pkg;
  // Upper-byte kind codes
  localparam logic [7:0] OP_ALWAYS = 8'h10;
  localparam logic [7:0] OP_NZ     = 8'h11;
  localparam logic [7:0] OP_ZR     = 8'h12;
  localparam logic [7:0] OP_POS    = 8'h13;
  localparam logic [7:0] OP_NEGV   = 8'h14;
  localparam logic [7:0] OP_NOOVF  = 8'h15;
  localparam logic [7:0] OP_OVF    = 8'h16;
  localparam logic [7:0] OP_NOCY   = 8'h17; // also unsigned higher-or-same
  localparam logic [7:0] OP_CY     = 8'h18; // also unsigned lower
  localparam logic [7:0] OP_SGE    = 8'h19;
  localparam logic [7:0] OP_SLT    = 8'h1A;
  localparam logic [7:0] OP_SGT    = 8'h1B;
  localparam logic [7:0] OP_SLE    = 8'h1C;
  localparam logic [7:0] OP_UGT    = 8'h1D;
  localparam logic [7:0] OP_ULE    = 8'h1E;
  localparam logic [7:0] OP_LOOP   = 8'h1F;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } bcu_flags_t;
endpackage

// File: rtl/bcu_cond.sv
`timescale 1ns/1ps
module bcu_cond
  import bcu_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic [OP_W-1:0] op,
  input  bcu_flags_t      fl,
  input  logic            loop_nz,
  output logic            is_loop,
  output logic            taken
);
  logic sgn_lt;
  logic sgn_le;
  logic uns_le;

  always_comb begin
    sgn_lt  = fl.n ^ fl.v;
    sgn_le  = fl.z | sgn_lt;
    uns_le  = fl.c | fl.z;
    is_loop = 1'b0;
    taken   = 1'b0;
    case (op)
      OP_W'(OP_ALWAYS): taken = 1'b1;
      OP_W'(OP_NZ):     taken = ~fl.z;
      OP_W'(OP_ZR):     taken = fl.z;
      OP_W'(OP_POS):    taken = ~fl.n;
      OP_W'(OP_NEGV):   taken = fl.n;
      OP_W'(OP_NOOVF):  taken = ~fl.v;
      OP_W'(OP_OVF):    taken = fl.v;
      OP_W'(OP_NOCY):   taken = ~fl.c;
      OP_W'(OP_CY):     taken = fl.c;
      OP_W'(OP_SGE):    taken = ~sgn_lt;
      OP_W'(OP_SLT):    taken = sgn_lt;
      OP_W'(OP_SGT):    taken = ~sgn_le;
      OP_W'(OP_SLE):    taken = sgn_le;
      OP_W'(OP_UGT):    taken = ~uns_le;
      OP_W'(OP_ULE):    taken = uns_le;
      OP_W'(OP_LOOP): begin
        is_loop = 1'b1;
        taken   = loop_nz;
      end
      default: taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/bcu_target.sv
`timescale 1ns/1ps
module bcu_target #(
  parameter int WORD_W = 16,
  parameter int OFF_W  = 8
) (
  input  logic [WORD_W-1:0] base,
  input  logic [OFF_W-1:0]  off,
  output logic [WORD_W-1:0] tgt
);
  localparam int EXT_W = WORD_W - OFF_W - 1;

  logic [WORD_W-1:0] disp;

  always_comb begin
    disp = {{EXT_W{off[OFF_W-1]}}, off, 1'b0};
    tgt  = base + disp;
  end
endmodule

// File: rtl/bcu_stage.sv
`timescale 1ns/1ps
module bcu_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [DATA_W-1:0] up_data,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [DATA_W-1:0] dn_data
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;

  assign up_ready = ~full_q | dn_ready;
  assign dn_valid = full_q;
  assign dn_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else if (up_ready) begin
      full_q <= up_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (up_valid && up_ready) begin
      data_q <= up_data;
    end
  end
endmodule

// File: rtl/bcu_branch_unit.sv
`timescale 1ns/1ps
module bcu_branch_unit
  import bcu_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int OFF_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_instr,
  input  logic [WORD_W-1:0] in_pc,
  input  logic [3:0]        in_flags,
  input  logic [WORD_W-1:0] in_count,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_taken,
  output logic [WORD_W-1:0] out_pc,
  output logic [WORD_W-1:0] out_count,
  output logic              out_count_wr
);
  localparam int OP_W  = WORD_W - OFF_W;
  localparam int RES_W = 2 * WORD_W + 2;

  logic [WORD_W-1:0] cnt_dec;
  logic [WORD_W-1:0] tgt;
  logic              is_loop;
  logic              taken;
  logic [WORD_W-1:0] pc_next;
  logic [WORD_W-1:0] cnt_next;
  logic [RES_W-1:0]  res_d;
  logic [RES_W-1:0]  res_q;

  assign cnt_dec = in_count - {{(WORD_W-1){1'b0}}, 1'b1};

  bcu_cond #(.OP_W(OP_W)) u_cond (
    .op      (in_instr[WORD_W-1:OFF_W]),
    .fl      (bcu_flags_t'(in_flags)),
    .loop_nz (|cnt_dec),
    .is_loop (is_loop),
    .taken   (taken)
  );

  bcu_target #(.WORD_W(WORD_W), .OFF_W(OFF_W)) u_tgt (
    .base (in_pc),
    .off  (in_instr[OFF_W-1:0]),
    .tgt  (tgt)
  );

  assign pc_next  = taken ? tgt : in_pc;
  assign cnt_next = is_loop ? cnt_dec : in_count;
  assign res_d    = {taken, is_loop, cnt_next, pc_next};

  bcu_stage #(.DATA_W(RES_W)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (res_d),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (res_q)
  );

  assign out_taken    = res_q[RES_W-1];
  assign out_count_wr = res_q[RES_W-2];
  assign out_count    = res_q[2*WORD_W-1:WORD_W];
  assign out_pc       = res_q[WORD_W-1:0];
endmodule

// File: rtl/bcu_checker.sv
`timescale 1ns/1ps
module bcu_checker #(
  parameter int WORD_W = 16,
  parameter int OFF_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [WORD_W-1:0] in_instr,
  input logic [WORD_W-1:0] in_pc,
  input logic [WORD_W-1:0] in_count,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_taken,
  input logic [WORD_W-1:0] out_pc,
  input logic [WORD_W-1:0] out_count,
  input logic              out_count_wr
);
  logic [WORD_W-1:0] sv_pc;
  logic [WORD_W-1:0] sv_count;
  logic [OFF_W-1:0]  sv_off;

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) begin
      sv_pc    <= in_pc;
      sv_count <= in_count;
      sv_off   <= in_instr[OFF_W-1:0];
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pc) &&
      $stable(out_taken) && $stable(out_count) && $stable(out_count_wr));

  assert_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_taken |->
      out_pc == sv_pc + WORD_W'({{(WORD_W-OFF_W){sv_off[OFF_W-1]}}, sv_off} * 2));

  assert_fallthrough_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_taken |-> out_pc == sv_pc);

  assert_loop_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_count_wr |->
      (out_count + WORD_W'(1) == sv_count) && (out_taken == (out_count != '0)));

  assert_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
endmodule

bind bcu_branch_unit bcu_checker #(.WORD_W(WORD_W), .OFF_W(OFF_W)) u_bcu_chk (.*);

// File: tb/tb_bcu_branch_unit.sv
`timescale 1ns/1ps
module tb_bcu_branch_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [15:0] in_instr;
  logic [15:0] in_pc;
  logic [3:0]  in_flags;
  logic [15:0] in_count;
  logic        out_valid;
  logic        out_ready;
  logic        out_taken;
  logic [15:0] out_pc;
  logic [15:0] out_count;
  logic        out_count_wr;

  always #2 clk = ~clk; // 250 MHz

  bcu_branch_unit dut (.*);

  typedef struct {
    logic [15:0] instr;
    logic [15:0] pc;
    logic [15:0] cnt;
    logic [3:0]  fl;
  } stim_t;

  typedef struct {
    logic        taken;
    logic        wr;
    logic [15:0] pc;
    logic [15:0] cnt;
    string       tag;
  } exp_t;

  stim_t stim_q[$];
  exp_t  exp_q[$];
  int checks = 0;
  int fails  = 0;

  task automatic chk(string tag, string what, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s actual %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic exp_t model(stim_t s);
    exp_t e;
    logic n, z, v, c;
    int op, off;
    n = s.fl[3]; z = s.fl[2]; v = s.fl[1]; c = s.fl[0];
    op  = int'(s.instr[15:8]);
    off = int'(s.instr[7:0]);
    if (off > 127) off = off - 256;
    e.wr = 1'b0; e.cnt = s.cnt; e.taken = 1'b0; e.tag = "R5";
    case (op)
      'h10: e.taken = 1'b1;
      'h11: e.taken = (z == 1'b0);
      'h12: e.taken = (z == 1'b1);
      'h13: e.taken = (n == 1'b0);
      'h14: e.taken = (n == 1'b1);
      'h15: e.taken = (v == 1'b0);
      'h16: e.taken = (v == 1'b1);
      'h17: begin e.taken = (c == 1'b0); e.tag = "R7"; end
      'h18: begin e.taken = (c == 1'b1); e.tag = "R7"; end
      'h19: begin e.taken = (n == v); e.tag = "R6"; end
      'h1A: begin e.taken = (n != v); e.tag = "R6"; end
      'h1B: begin e.taken = !z && (n == v); e.tag = "R6"; end
      'h1C: begin e.taken = z || (n != v); e.tag = "R6"; end
      'h1D: begin e.taken = !c && !z; e.tag = "R7"; end
      'h1E: begin e.taken = c || z; e.tag = "R7"; end
      'h1F: begin
        e.wr = 1'b1;
        e.cnt = 16'((int'(s.cnt) + 65535) % 65536);
        e.taken = (e.cnt != 16'h0);
        e.tag = "R8";
      end
      default: e.tag = "R9";
    endcase
    e.pc = e.taken ? 16'(int'(s.pc) + 2 * off) : s.pc;
    return e;
  endfunction

  task automatic add(logic [15:0] instr, logic [15:0] pc, logic [3:0] fl, logic [15:0] cnt);
    stim_t s;
    s.instr = instr; s.pc = pc; s.fl = fl; s.cnt = cnt;
    stim_q.push_back(s);
  endtask

  initial begin
    stim_t cur;
    exp_t  e;
    bit    accepted;
    bit    prev_fire;
    bit    held;
    logic [15:0] h_pc, h_cnt;
    logic  h_tk, h_wr;
    int    cycles;

    // directed corners
    add(16'h1F12, 16'h0400, 4'h0, 16'h0001); // R8 counter 1 falls through
    add(16'h1F12, 16'h0400, 4'h0, 16'h0000); // R8 counter 0 wraps, taken
    add(16'h1080, 16'h1000, 4'h0, 16'h0000); // R3 most negative offset
    add(16'h107F, 16'h1000, 4'h0, 16'h0000); // R3 most positive offset
    add(16'h1001, 16'hFFFE, 4'h0, 16'h0000); // R3 wrap upward
    add(16'h10FF, 16'h0002, 4'h0, 16'h0000); // R3 target zero
    add(16'h10FE, 16'h0001, 4'h0, 16'h0000); // R3 wrap downward
    add(16'h0010, 16'h2222, 4'hF, 16'h0005); // R9 below code range
    add(16'h2010, 16'h2222, 4'hF, 16'h0005); // R9 above code range
    add(16'h8005, 16'h3000, 4'h0, 16'h0009); // R9 high codes
    for (int op = 'h0F; op <= 'h20; op++)
      for (int f = 0; f < 16; f++)
        add(16'((op << 8) | (f * 13 + 3) % 256), 16'(op * 517 + f * 97), 4'(f), 16'(f % 3));
    for (int i = 0; i < 2000; i++)
      add({8'($urandom_range('h0E, 'h21)), 8'($urandom)}, 16'($urandom), 4'($urandom),
          16'($urandom_range(0, 3) == 0 ? $urandom_range(0, 2) : $urandom));

    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_instr = '0; in_pc = '0; in_flags = '0; in_count = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "out_valid in reset", 16'(out_valid), 16'h0);
    chk("R1", "in_ready in reset", 16'(in_ready), 16'h1);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "out_valid after reset", 16'(out_valid), 16'h0);
    chk("R1", "in_ready after reset", 16'(in_ready), 16'h1);

    accepted = 1'b0; prev_fire = 1'b0; held = 1'b0; cycles = 0;
    while (stim_q.size() != 0 || exp_q.size() != 0 || in_valid) begin
      @(negedge clk);
      if (accepted) begin in_valid = 1'b0; accepted = 1'b0; end
      if (!in_valid && stim_q.size() != 0 && $urandom_range(0, 4) != 0) begin
        cur = stim_q.pop_front();
        in_valid = 1'b1; in_instr = cur.instr; in_pc = cur.pc;
        in_flags = cur.fl; in_count = cur.cnt;
      end
      out_ready = ($urandom_range(0, 3) != 0);
      #1;
      if (prev_fire) chk("R10", "out_valid after accept", 16'(out_valid), 16'h1);
      if (held) begin
        chk("R2", "held valid", 16'(out_valid), 16'h1);
        chk("R2", "held pc", out_pc, h_pc);
        chk("R2", "held taken/wr", {14'h0, out_taken, out_count_wr}, {14'h0, h_tk, h_wr});
        chk("R2", "held count", out_count, h_cnt);
      end
      chk("R2", "in_ready rule", 16'(in_ready), 16'(!out_valid || out_ready));
      held = out_valid && !out_ready;
      h_pc = out_pc; h_cnt = out_count; h_tk = out_taken; h_wr = out_count_wr;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk("R10", "unexpected output", 16'h1, 16'h0);
        end else begin
          e = exp_q.pop_front();
          chk(e.tag, "taken", 16'(out_taken), 16'(e.taken));
          chk(e.taken ? "R3" : "R4", "pc", out_pc, e.pc);
          chk(e.wr ? "R8" : "R9", "count write", 16'(out_count_wr), 16'(e.wr));
          if (e.wr) chk("R8", "count", out_count, e.cnt);
        end
      end
      prev_fire = in_valid && in_ready;
      if (prev_fire) begin
        exp_q.push_back(model(cur));
        accepted = 1'b1;
      end
      cycles++;
      if (cycles > 100000) begin
        chk("R10", "watchdog expired", 16'h1, 16'h0);
        break;
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule